// File: doc/BRIEF.md
# Over-Power Energy Integrator

This block is a digital stand-in for the thermal energy store that guards a high-side power switch against turn-ons that never complete. While the gate drive is above the transistor threshold but the drain-source voltage has not yet fallen below the 0.75 V "fully on" mark, an unsigned accumulator gains a fixed charge step on every clock. As soon as the drain-source voltage is low, the switch is known to be properly on and the accumulator is emptied at once. A slow leak removes one unit every `LEAK_DIV` clocks in all states, so energy from brief failed pulses stays in store between PWM periods, and several short bad pulses in a row can build up to a trip.

When the accumulator holds its full-scale value, a registered fault flag is set. The flag stays set whatever the switch inputs do, and only the sleep-mode reset clears it. The sleep reset also empties the accumulator and restarts the leak phase. This covers a missing or leaky bootstrap capacitor, gate leakage and hard output shorts. With the default parameters at 250 MHz, continuous charging trips in about 9 µs, and a full store drains in about 11 ms.

All pins are plain level control or status signals. No data stream crosses the block's edge, so there is no handshake.

Top module: `overpower_integrator`

## Requirements
- R1: While `rst_n` is low, `fault` is 0 and the accumulator is 0. After reset release, `fault` stays 0 until a trip.
- R2: On each rising edge with `gate_on`=1 and `vds_low`=0, the accumulator gains `CHARGE_STEP`. `fault` becomes 1 at the rising edge that follows the edge at which the accumulator reached `FULL_SCALE`.
- R3: On a rising edge with `vds_low`=1, the accumulator becomes 0. This overrides both charge and leak.
- R4: With `gate_on`=0 and `vds_low`=0, no charge is added and the value is kept (apart from leak). The next charge resumes from the kept value, so separate pulses add up to a trip.
- R5: One unit is removed at every `LEAK_DIV`-th rising edge, counted from reset or sleep-reset release. If charge and leak fall on the same edge, the net change (step minus one) is applied.
- R6: The accumulator saturates. It never goes below 0 under leak and never exceeds `FULL_SCALE` under charge.
- R7: Once set, `fault` stays 1 under any combination of `gate_on` and `vds_low` until a sleep reset.
- R8: A rising edge with `sleep_rst`=1 clears `fault`, empties the accumulator and restarts the leak phase. This takes priority over every other input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| sleep_rst | input | 1 | Sleep-mode reset pulse. Clears the fault and the stored energy |
| gate_on | input | 1 | Gate voltage is above the transistor threshold |
| vds_low | input | 1 | Drain-source voltage is below 0.75 V (switch fully on) |
| fault | output | 1 | Latched over-power fault |

## Verification
Any input change reaches the accumulator at the first rising edge after it. The fault flag is due one edge later than the accumulator reaching full scale, so a trip appears two edges after the charging input that completes it. Sleep reset and clear act at the first edge. The bench drives inputs on the falling edge and updates its own cycle model for the coming rising edge. It queues the expected `fault` value, and the monitor takes that value from the queue 1 ns after the rising edge. In this way each expected value is compared in exactly the cycle in which it is due, including the leak phase counted from each reset.

// File: rtl/opi_pkg.sv
package opi_pkg;

  // Action applied to the energy store on the coming edge
  typedef enum logic [1:0] {
    ACT_HOLD   = 2'd0,  // no charge, leak only
    ACT_CHARGE = 2'd1,  // gate on, switch not yet fully on
    ACT_CLEAR  = 2'd2   // switch fully on: empty the store
  } acc_act_e;

  function automatic int acc_width(input int full_scale);
    return $clog2(full_scale + 1);
  endfunction

endpackage

// File: rtl/opi_action_decode.sv
module opi_action_decode
  import opi_pkg::*;
(
  input  logic     gate_on,
  input  logic     vds_low,
  output acc_act_e act
);

  always_comb begin
    if (vds_low)      act = ACT_CLEAR;
    else if (gate_on) act = ACT_CHARGE;
    else              act = ACT_HOLD;
  end

endmodule

// File: rtl/opi_leak_timer.sv
module opi_leak_timer #(
  parameter int LEAK_DIV = 1222
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sleep_rst,
  output logic leak_tick
);

  generate
    if (LEAK_DIV <= 1) begin : g_every_cycle
      assign leak_tick = 1'b1;
    end else begin : g_prescale
      localparam int CNT_W = $clog2(LEAK_DIV);
      localparam logic [CNT_W-1:0] LAST = CNT_W'(LEAK_DIV - 1);
      logic [CNT_W-1:0] cnt_q;

      assign leak_tick = (cnt_q == LAST);

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cnt_q <= '0;
        else if (sleep_rst)  cnt_q <= '0;
        else if (leak_tick)  cnt_q <= '0;
        else                 cnt_q <= cnt_q + 1'b1;
      end
    end
  endgenerate

endmodule

// File: rtl/opi_accumulator.sv
module opi_accumulator
  import opi_pkg::*;
#(
  parameter int FULL_SCALE  = 2250,
  parameter int CHARGE_STEP = 1,
  localparam int ACC_W      = acc_width(FULL_SCALE)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sleep_rst,
  input  acc_act_e         act,
  input  logic             leak_tick,
  output logic [ACC_W-1:0] level,
  output logic             at_full
);

  localparam int SUM_W = ACC_W + 1;
  localparam logic [SUM_W-1:0] STEP_S = SUM_W'(CHARGE_STEP);
  localparam logic [SUM_W-1:0] FULL_S = SUM_W'(FULL_SCALE);
  localparam logic [ACC_W-1:0] FULL_A = ACC_W'(FULL_SCALE);

  logic [ACC_W-1:0] acc_q;
  logic [SUM_W-1:0] raised;
  logic [SUM_W-1:0] drained;
  logic [ACC_W-1:0] acc_d;

  always_comb begin
    raised  = {1'b0, acc_q} + ((act == ACT_CHARGE) ? STEP_S : '0);
    drained = (leak_tick && (raised != '0)) ? raised - 1'b1 : raised;
    if (act == ACT_CLEAR)       acc_d = '0;
    else if (drained > FULL_S)  acc_d = FULL_A;
    else                        acc_d = drained[ACC_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         acc_q <= '0;
    else if (sleep_rst) acc_q <= '0;
    else                acc_q <= acc_d;
  end

  assign level   = acc_q;
  assign at_full = (acc_q == FULL_A);

endmodule

// File: rtl/opi_fault_latch.sv
module opi_fault_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic sleep_rst,
  input  logic trip,
  output logic fault
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         fault <= 1'b0;
    else if (sleep_rst) fault <= 1'b0;
    else if (trip)      fault <= 1'b1;
  end

endmodule

// File: rtl/overpower_integrator.sv
module overpower_integrator
  import opi_pkg::*;
#(
  parameter int FULL_SCALE  = 2250,
  parameter int CHARGE_STEP = 1,
  parameter int LEAK_DIV    = 1222
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sleep_rst,
  input  logic gate_on,
  input  logic vds_low,
  output logic fault
);

  localparam int ACC_W = acc_width(FULL_SCALE);

  acc_act_e         act;
  logic             leak_tick;
  logic [ACC_W-1:0] acc_lvl;
  logic             at_full;

  opi_action_decode u_decode (
    .gate_on (gate_on),
    .vds_low (vds_low),
    .act     (act)
  );

  opi_leak_timer #(.LEAK_DIV(LEAK_DIV)) u_leak (
    .clk       (clk),
    .rst_n     (rst_n),
    .sleep_rst (sleep_rst),
    .leak_tick (leak_tick)
  );

  opi_accumulator #(
    .FULL_SCALE  (FULL_SCALE),
    .CHARGE_STEP (CHARGE_STEP)
  ) u_acc (
    .clk       (clk),
    .rst_n     (rst_n),
    .sleep_rst (sleep_rst),
    .act       (act),
    .leak_tick (leak_tick),
    .level     (acc_lvl),
    .at_full   (at_full)
  );

  opi_fault_latch u_latch (
    .clk       (clk),
    .rst_n     (rst_n),
    .sleep_rst (sleep_rst),
    .trip      (at_full),
    .fault     (fault)
  );

endmodule

// File: rtl/opi_checker.sv
module opi_checker #(
  parameter int FULL_SCALE  = 2250,
  parameter int CHARGE_STEP = 1,
  parameter int ACC_W       = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sleep_rst,
  input logic             gate_on,
  input logic             vds_low,
  input logic             fault,
  input logic [ACC_W-1:0] acc,
  input logic             leak_tick
);

  localparam logic [ACC_W-1:0] FULL_V = ACC_W'(FULL_SCALE);
  localparam logic [ACC_W-1:0] STEP_V = ACC_W'(CHARGE_STEP);
  localparam logic [ACC_W-1:0] ROOM_V = ACC_W'(FULL_SCALE - CHARGE_STEP);

  always_comb begin
    if (!rst_n) begin
      p_reset_quiet_r1: assert (!fault && acc == '0);
    end
  end

  p_no_spurious_trip_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault) |-> $past(acc) == FULL_V);

  p_charge_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_on && !vds_low && !sleep_rst && !leak_tick && acc <= ROOM_V)
    |=> acc == $past(acc) + STEP_V);

  p_trip_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc == FULL_V && !sleep_rst) |=> fault);

  p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (vds_low && !sleep_rst) |=> acc == '0);

  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!gate_on && !vds_low && !leak_tick && !sleep_rst) |=> $stable(acc));

  p_leak_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!gate_on && !vds_low && leak_tick && !sleep_rst && acc != '0)
    |=> acc == $past(acc) - 1'b1);

  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    acc <= FULL_V);

  p_fault_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fault && !sleep_rst) |=> fault);

  p_sleep_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_rst |=> (!fault && acc == '0));

endmodule

bind overpower_integrator opi_checker #(
  .FULL_SCALE  (FULL_SCALE),
  .CHARGE_STEP (CHARGE_STEP),
  .ACC_W       (opi_pkg::acc_width(FULL_SCALE))
) u_opi_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .sleep_rst (sleep_rst),
  .gate_on   (gate_on),
  .vds_low   (vds_low),
  .fault     (fault),
  .acc       (acc_lvl),
  .leak_tick (leak_tick)
);

// File: tb/test_overpower_integrator.sv
module test_overpower_integrator;

  localparam int FULL  = 64;
  localparam int STEP  = 4;
  localparam int LDIV  = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sleep_rst = 1'b0;
  logic gate_on = 1'b0;
  logic vds_low = 1'b0;
  logic fault;

  int n_checks = 0;
  int n_fail   = 0;

  // reference model state
  int  m_acc = 0;
  int  m_cnt = 0;
  bit  m_flt = 1'b0;

  bit    q_exp[$];
  string q_tag[$];
  bit    e_val;
  string e_tag;

  always #2 clk = ~clk;

  overpower_integrator #(
    .FULL_SCALE  (FULL),
    .CHARGE_STEP (STEP),
    .LEAK_DIV    (LDIV)
  ) i_overpower_integrator (
    .clk       (clk),
    .rst_n     (rst_n),
    .sleep_rst (sleep_rst),
    .gate_on   (gate_on),
    .vds_low   (vds_low),
    .fault     (fault)
  );

  task automatic check(input bit cond, input string tag, input bit act, input bit exp);
    n_checks++;
    if (!cond) begin
      n_fail++;
      $display("FAIL %s: fault=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  // drive one cycle and queue the fault value due after the next rising edge
  task automatic step(input bit g, input bit v, input bit s, input string tag);
    bit tick;
    int n;
    @(negedge clk);
    gate_on   = g;
    vds_low   = v;
    sleep_rst = s;
    if (s) begin
      m_acc = 0; m_cnt = 0; m_flt = 1'b0;
    end else begin
      tick  = (m_cnt == LDIV - 1);
      m_cnt = tick ? 0 : m_cnt + 1;
      if (m_acc == FULL) m_flt = 1'b1;
      if (v) m_acc = 0;
      else begin
        n = m_acc + (g ? STEP : 0);
        if (tick && n > 0) n = n - 1;
        if (n > FULL) n = FULL;
        m_acc = n;
      end
    end
    q_exp.push_back(m_flt);
    q_tag.push_back(tag);
  endtask

  task automatic run(input int cycles, input bit g, input bit v, input string tag);
    for (int i = 0; i < cycles; i++) step(g, v, 1'b0, tag);
  endtask

  // monitor: compare 1 ns after each rising edge
  always @(posedge clk) begin
    #1;
    if (q_exp.size() > 0) begin
      e_val = q_exp.pop_front();
      e_tag = q_tag.pop_front();
      check(fault === e_val, e_tag, fault, e_val);
    end
  end

  task automatic summary();
    $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    summary();
  end

  initial begin
    // R1: reset state
    repeat (3) @(posedge clk);
    #1 check(fault === 1'b0, "R1 reset", fault, 1'b0);
    @(negedge clk) rst_n = 1'b1;
    run(5, 1'b0, 1'b0, "R1 idle after reset");

    // R2: continuous charge trips; R7: fault sticks
    run(30, 1'b1, 1'b0, "R2 charge to trip");
    #2 check(fault === 1'b1, "R2 tripped", fault, 1'b1);
    run(10, 1'b0, 1'b1, "R7 sticky under vds_low");
    run(10, 1'b0, 1'b0, "R7 sticky idle");
    run(5,  1'b1, 1'b0, "R7 sticky charging");
    step(1'b0, 1'b0, 1'b1, "R8 sleep clears");
    run(3, 1'b0, 1'b0, "R8 after sleep");

    // R3: clear mid-charge postpones the trip
    run(12, 1'b1, 1'b0, "R3 partial charge");
    step(1'b1, 1'b1, 1'b0, "R3 clear overrides charge");
    run(14, 1'b1, 1'b0, "R3 recharge no trip");
    #2 check(fault === 1'b0, "R3 no trip after clear", fault, 1'b0);
    run(10, 1'b1, 1'b0, "R3 eventual trip");
    step(1'b0, 1'b0, 1'b1, "R8 sleep");

    // R4: short pulses accumulate
    for (int p = 0; p < 5; p++) begin
      run(6, 1'b1, 1'b0, "R4 pulse on");
      run(4, 1'b0, 1'b0, "R4 pulse off hold");
    end
    step(1'b0, 1'b0, 1'b1, "R8 sleep");

    // R5/R6: leak drains to zero and saturates there
    run(10,  1'b1, 1'b0, "R5 partial charge");
    run(400, 1'b0, 1'b0, "R5 leak drain");
    run(15,  1'b1, 1'b0, "R6 no underflow, no early trip");
    #2 check(fault === 1'b0, "R6 empty after drain", fault, 1'b0);
    run(10,  1'b1, 1'b0, "R5 trip after drain");
    step(1'b0, 1'b0, 1'b1, "R8 sleep");

    // R5: leak during charge plus partial leak between pulses
    run(9,  1'b1, 1'b0, "R5 charge with leak");
    run(37, 1'b0, 1'b0, "R5 partial leak");
    run(9,  1'b1, 1'b0, "R5 resume charge");
    step(1'b0, 1'b0, 1'b1, "R8 sleep");

    // R6: long charge saturates at full scale
    run(40, 1'b1, 1'b0, "R6 saturate top");
    run(3,  1'b0, 1'b0, "R6 hold full");
    step(1'b0, 1'b0, 1'b1, "R8 sleep");

    // R8: sleep reset overrides charge and restarts leak phase
    run(14, 1'b1, 1'b0, "R8 charge before sleep");
    step(1'b1, 1'b0, 1'b1, "R8 sleep over charge");
    run(15, 1'b1, 1'b0, "R8 no trip after sleep");
    #2 check(fault === 1'b0, "R8 store emptied", fault, 1'b0);
    run(10, 1'b1, 1'b0, "R8 trip again");
    run(2, 1'b0, 1'b0, "R7 final idle");

    @(posedge clk);
    #3;
    summary();
  end

endmodule